// File: doc/BRIEF.md
# Board control register block

A small memory-mapped peripheral for board bring-up. It sits on a simple 32-bit read/write bus with a select, a write-enable, a byte address, write data and read data. It occupies a 64 KB window, of which only the first few words are decoded.

Software reads two fixed identification words from it: a build-date code and the processor clock frequency in Hz. It can also write and read back an LED register whose bits drive output pins, and it can read a synchronized view of DIP switch inputs. Writing one magic key to a dedicated word produces a single-cycle, registered board reset request. The block that owns system reset turns that request into a real reset.

Reads are registered: the read data appears one cycle after the read strobe and then holds until the next read. Only word-aligned 32-bit accesses are meaningful, and address bits [1:0] are ignored.

Top module: `board_ctrl_regs`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, led_out is 0, bus_rdata is 0 and reset_req is 0.
- R2: A read (bus_sel=1, bus_we=0) of offset 0x0 makes bus_rdata equal 0x09272011 in the cycle after the strobe.
- R3: A read of offset 0x4 makes bus_rdata equal 10000000 (0x00989680) in the cycle after the strobe.
- R4: A write (bus_sel=1, bus_we=1) to offset 0x8 stores bus_wdata[LED_W-1:0] into the LED register, which appears on led_out in the next cycle (1 = LED on). A read of 0x8 returns the register zero-extended to 32 bits. No other access changes led_out.
- R5: A read of offset 0xC returns sw_in zero-extended, after a two-flop synchronizer: the value returned is sw_in as sampled two clock edges before the read edge. A write to 0xC changes neither led_out nor any value read back.
- R6: A write of exactly 0x0000DEAD to offset 0x10 drives reset_req high for the one cycle after the write. A write of any other value to 0x10, and any access elsewhere, leaves reset_req low.
- R7: A read of any offset other than 0x0, 0x4, 0x8 and 0xC returns 0, including 0x10 and the top of the 64 KB window. Writes to such offsets have no effect on led_out or on later reads.
- R8: Address bits [1:0] are ignored, so offset 0x9 or 0xB reaches the LED register.
- R9: bus_rdata changes only in the cycle after a read strobe. Otherwise it holds its last value, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this window |
| bus_we | input | 1 | 1 = write, 0 = read while selected |
| bus_addr | input | ADDR_W (16) | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sw_in | input | SW_W (8) | Asynchronous DIP switch inputs, 1 = on |
| led_out | output | LED_W (8) | LED drive, 1 = lit |
| reset_req | output | 1 | Single-cycle board reset request |

## Verification
A corrupted LED register shows up on led_out in the very next cycle, and also in the next readback of 0x8. A stuck or wrongly staged synchronizer makes a 0xC read, issued right after a switch change, return the old value or the new one one cycle too early. The reset-request flop is checked in every cycle, so an extra, missing or stretched pulse is caught at the edge where it happens. A bad read multiplexer or a bad hold on bus_rdata shows one cycle after the strobe, or in the idle cycles that follow it.

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs #(
  parameter int          ADDR_W   = 16,
  parameter int          LED_W    = 8,
  parameter int          SW_W     = 8,
  parameter logic [31:0] BUILD_ID = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ   = 32'd10_000_000,
  parameter logic [31:0] RST_KEY  = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [SW_W-1:0]   sw_in,
  output logic [LED_W-1:0]  led_out,
  output logic              reset_req
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              rd, wr;
  logic [SW_W-1:0]   sw_meta, sw_sync;
  logic [LED_W-1:0]  led_q;
  logic [31:0]       rd_mux;
  logic              unused_lsb;

  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign rd         = bus_sel & ~bus_we;
  assign wr         = bus_sel & bus_we;
  assign led_out    = led_q;

  always_comb begin
    case (word)
      WORD_W'(0): rd_mux = BUILD_ID;
      WORD_W'(1): rd_mux = CLK_HZ;
      WORD_W'(2): rd_mux = 32'(led_q);
      WORD_W'(3): rd_mux = 32'(sw_sync);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_meta   <= '0;
      sw_sync   <= '0;
      led_q     <= '0;
      bus_rdata <= '0;
      reset_req <= 1'b0;
    end else begin
      sw_meta   <= sw_in;
      sw_sync   <= sw_meta;
      reset_req <= wr && (word == WORD_W'(4)) && (bus_wdata == RST_KEY);
      if (wr && word == WORD_W'(2)) led_q <= bus_wdata[LED_W-1:0];
      if (rd) bus_rdata <= rd_mux;
    end
  end
endmodule

module board_ctrl_regs_chk #(
  parameter int          ADDR_W   = 16,
  parameter int          LED_W    = 8,
  parameter logic [31:0] BUILD_ID = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ   = 32'd10_000_000,
  parameter logic [31:0] RST_KEY  = 32'h0000_DEAD
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [LED_W-1:0]  led_out,
  input logic              reset_req
);
  logic [ADDR_W-3:0] widx;
  logic              c_rd, c_wr, c_key;
  assign widx  = bus_addr[ADDR_W-1:2];
  assign c_rd  = bus_sel && !bus_we;
  assign c_wr  = bus_sel && bus_we;
  assign c_key = c_wr && (widx == 4) && (bus_wdata == RST_KEY);

  a_r2_build_id: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && widx == 0) |=> (bus_rdata == BUILD_ID));
  a_r3_clock_word: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && widx == 1) |=> (bus_rdata == CLK_HZ));
  a_r4_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_wr && widx == 2) |=> $stable(led_out));
  a_r6_req_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(c_key));
  a_r6_key_gives_req: assert property (@(posedge clk) disable iff (!rst_n)
    c_key |=> reset_req);
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && widx > 3) |=> (bus_rdata == 32'd0));
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd |=> $stable(bus_rdata));
endmodule

bind board_ctrl_regs board_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .LED_W(LED_W), .BUILD_ID(BUILD_ID), .CLK_HZ(CLK_HZ), .RST_KEY(RST_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_out(led_out), .reset_req(reset_req)
);

// File: tb/board_ctrl_regs_bench.sv
module board_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  sw_in = '0;
  logic [7:0]  led_out;
  logic        reset_req;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string tag = "R1";

  logic [7:0]  m_led = '0;
  logic [31:0] m_rdata = '0;
  logic        m_req = 1'b0;
  logic [7:0]  m_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  board_ctrl_regs u_board_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_in(sw_in), .led_out(led_out),
    .reset_req(reset_req)
  );

  // Reference model, advanced at every rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_led = '0; m_rdata = '0; m_req = 1'b0;
      m_hist = {8'h00, 8'h00};
    end else begin
      int off;
      off = int'(bus_addr) & 32'hFFFC;
      if (bus_sel && !bus_we) begin
        if (off == 0)         m_rdata = 32'h0927_2011;
        else if (off == 4)    m_rdata = 32'd10000000;
        else if (off == 8)    m_rdata = {24'd0, m_led};
        else if (off == 'hC)  m_rdata = {24'd0, m_hist[1]};
        else                  m_rdata = 32'd0;
      end
      m_req = bus_sel && bus_we && off == 'h10 && bus_wdata == 32'h0000_DEAD;
      if (bus_sel && bus_we && off == 8) m_led = bus_wdata[7:0];
      m_hist.push_front(sw_in);
      void'(m_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks += 3;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL %s bus_rdata actual %h expected %h", tag, bus_rdata, m_rdata);
      end
      if (led_out !== m_led) begin
        errors++;
        $display("FAIL %s led_out actual %h expected %h", tag, led_out, m_led);
      end
      if (reset_req !== m_req) begin
        errors++;
        $display("FAIL %s reset_req actual %b expected %b", tag, reset_req, m_req);
      end
    end
  end

  task automatic step(input logic s, input logic w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
  endtask
  task automatic wr(input logic [15:0] a, input logic [31:0] d); step(1'b1, 1'b1, a, d); endtask
  task automatic rd(input logic [15:0] a); step(1'b1, 1'b0, a, 32'h0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired at tag %s", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R1"; sw_in = 8'h81;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    tag = "R2"; rd(16'h0000); idle(1);
    tag = "R3"; rd(16'h0004); idle(1);
    tag = "R4"; wr(16'h0008, 32'h0000_00A5); rd(16'h0008);
    wr(16'h0008, 32'hFFFF_F15A); rd(16'h0008); idle(1);
    tag = "R5"; sw_in = 8'h3C; idle(3); rd(16'h000C);
    wr(16'h000C, 32'h0000_0000); rd(16'h000C); rd(16'h0008);
    sw_in = 8'hC3; rd(16'h000C); rd(16'h000C); rd(16'h000C); idle(1);
    tag = "R6"; wr(16'h0010, 32'h0000_DEAD); idle(2);
    wr(16'h0010, 32'h0000_DEAE); wr(16'h0010, 32'h0001_DEAD);
    wr(16'h0014, 32'h0000_DEAD); wr(16'h0010, 32'h0000_DEAD);
    wr(16'h0010, 32'h0000_DEAD); idle(2);
    tag = "R7"; rd(16'h0010); rd(16'h0014); rd(16'hFFFC); rd(16'h0004);
    wr(16'h0014, 32'h0000_0011); wr(16'hFFF8, 32'h0000_0022);
    rd(16'h8008); rd(16'h0008); idle(1);
    tag = "R8"; wr(16'h000B, 32'h0000_0077); rd(16'h0009); rd(16'h0002); idle(1);
    tag = "R9"; rd(16'h0000); idle(3); wr(16'h0008, 32'h0000_0001);
    wr(16'h0010, 32'h0000_DEAD); idle(2); rd(16'h0008); idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule